// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Idle Suspension

The block is a system-monitor timer that runs at the oscillator clock. Its counting chain has three stages. A fixed divide-by-12 stage comes first. A power-of-two prescaler follows it, with its ratio picked by a 3-bit code. The last stage is a wide time-out counter, 14 bits by default. When the watchdog is enabled and the time-out counter rolls over, the block raises a one-cycle internal reset request. The counter then starts again from zero.

Software controls the block through one 8-bit control register, which has a write strobe and a readback path. The register holds an enable bit, a restart bit, an idle-run bit and the prescaler code. The restart bit returns the whole counting chain to zero and then clears itself. The idle-run bit decides whether counting goes on while the system reports idle mode. A system reset disables the watchdog and zeroes the whole chain.

Top module: `wdog_top`

## Requirements
- R1: The control register fields are: enable at bit 7, restart at bit 6, idle-run at bit 5 and prescaler code at bits 2:0. A write loads all of them. Bits 4 and 3 always read 0, even after a write of 1.
- R2: After the enabling write edge, with no reset or restart since the last reset, the first time-out request comes exactly 12 × P × 2^CNT_W clock edges later, where P is the prescaler ratio.
- R3: Prescaler code c (0 to 7) selects a ratio of 2^(c+1). Code 0 gives 2 and code 7 gives 256.
- R4: The time-out request is high for exactly one cycle. The counter wraps, so the next request follows another full period later.
- R5: A write with bit 6 set makes the next clock edge zero the divide-by-12 stage, the prescaler and the counter. A new full period then begins after that edge.
- R6: The restart bit reads 1 only in the cycle after the write that set it. After that it reads 0 by itself.
- R7: A system reset clears the register to 0x00 and zeroes the counting chain. After re-enabling, a full period passes before the next request.
- R8: While the enable bit is 0, no request is raised and the chain holds its count. Enabling again resumes from the held count.
- R9: With the idle-run bit at 0, every clock edge spent in idle leaves the chain frozen, so the request is delayed by the number of idle cycles.
- R10: With the idle-run bit at 1, idle has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous system reset, active high |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| idle | input | 1 | High while the system is in idle mode |
| rd_data | output | 8 | Control register readback |
| tmo_req | output | 1 | One-cycle internal reset request on time-out |

## Verification
The assertions take for granted that reset is held for at least one edge before any write. They also assume that the restart bit is not written again in the cycle after it was set, so that its self-clearing can be observed. The stimulus always writes the register for one cycle at a time and drives the inputs only on falling edges. It never rewrites the restart bit back to back. The bench uses a 3-bit time-out counter so that all eight prescaler codes can be swept to their first request within the run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int SEL_W  = 3;
    localparam int REG_W  = 8;
    localparam int B_EN   = 7;
    localparam int B_CLR  = 6;
    localparam int B_WIDL = 5;

    typedef struct packed {
        logic             en;
        logic             clr;
        logic             widl;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

endpackage

// File: rtl/wdog_fixdiv.sv
module wdog_fixdiv #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int W = $clog2(DIV);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (run) begin
            if (st_q.cnt == W'(DIV - 1)) begin
                st_d.cnt = '0;
                tick     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_out
);
    localparam int PW = 1 << SEL_W;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } st_t;

    st_t         st_d, st_q;
    logic [PW:0] lim_w;
    logic [PW-1:0] lim;

    always_comb begin
        lim_w    = ((PW+1)'(1) << (32'(sel) + 1)) - (PW+1)'(1);
        lim      = lim_w[PW-1:0];
        st_d     = st_q;
        tick_out = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick_in) begin
            if (st_q.cnt >= lim) begin
                st_d.cnt = '0;
                tick_out = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick_in,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick_in) begin
            wrap     = &st_q.cnt;
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R5

endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
    parameter int CNT_W   = 14,
    parameter int FIX_DIV = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       idle,
    output logic [7:0] rd_data,
    output logic       tmo_req
);
    import wdog_pkg::*;

    typedef struct packed {
        ctrl_t ctrl;
        logic  req;
    } st_t;

    st_t              st_d, st_q;
    logic             run;
    logic             div_tick;
    logic             pre_tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        run  = st_q.ctrl.en && !(idle && !st_q.ctrl.widl);
        st_d = st_q;
        if (st_q.ctrl.clr) st_d.ctrl.clr = 1'b0;
        if (wr_en) begin
            st_d.ctrl.en   = wr_data[B_EN];
            st_d.ctrl.clr  = wr_data[B_CLR];
            st_d.ctrl.widl = wr_data[B_WIDL];
            st_d.ctrl.sel  = wr_data[SEL_W-1:0];
        end
        st_d.req = wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    wdog_fixdiv #(.DIV(FIX_DIV)) i_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (st_q.ctrl.clr),
        .run  (run),
        .tick (div_tick)
    );

    wdog_prescale #(.SEL_W(SEL_W)) i_pre (
        .clk      (clk),
        .rst      (rst),
        .clr      (st_q.ctrl.clr),
        .tick_in  (div_tick),
        .sel      (st_q.ctrl.sel),
        .tick_out (pre_tick)
    );

    wdog_count #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (st_q.ctrl.clr),
        .tick_in (pre_tick),
        .wrap    (wrap),
        .cnt     (cnt)
    );

    always_comb begin
        rd_data                = '0;
        rd_data[B_EN]          = st_q.ctrl.en;
        rd_data[B_CLR]         = st_q.ctrl.clr;
        rd_data[B_WIDL]        = st_q.ctrl.widl;
        rd_data[SEL_W-1:0]     = st_q.ctrl.sel;
    end

    assign tmo_req = st_q.req;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        tmo_req |=> !tmo_req); // R4

    AST_CLR_SELF: assert property (@(posedge clk) disable iff (rst)
        (rd_data[B_CLR] && !(wr_en && wr_data[B_CLR])) |=> !rd_data[B_CLR]); // R6

    AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !rd_data[B_EN] |=> !tmo_req); // R8

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (idle && !rd_data[B_WIDL] && !rd_data[B_CLR]) |=> $stable(cnt)); // R9

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[4:3] == 2'b00)); // R1

endmodule

// File: tb/test_wdog_top.sv
`timescale 1ns/1ps
module test_wdog_top;

    localparam int CW  = 3;
    localparam int DIV = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       idle = 1'b0;
    logic [7:0] rd_data;
    logic       tmo_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    wdog_top #(.CNT_W(CW), .FIX_DIV(DIV)) i_wdog_top (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .idle    (idle),
        .rd_data (rd_data),
        .tmo_req (tmo_req)
    );

    function automatic int period(int code);
        return DIV * (2 << code) * (1 << CW);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_pulse(int exp, string tag);
        int found = -1;
        for (int j = 1; j <= exp + 8; j++) begin
            @(negedge clk);
            if (tmo_req) begin
                found = j;
                break;
            end
        end
        chk(found == exp, tag, found, exp);
    endtask

    task automatic run_quiet(int n, string tag);
        int hits = 0;
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            if (tmo_req) hits++;
        end
        chk(hits == 0, tag, hits, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R7: reset state
        chk(rd_data == 8'h00, "R7 reset readback", rd_data, 0);
        chk(tmo_req == 1'b0, "R7 reset request", tmo_req, 0);

        // R1/R6: fields, reserved bits, restart bit readback
        wr(8'hFF);
        chk(rd_data == 8'hE7, "R1 R6 readback after write", rd_data, 8'hE7);
        @(negedge clk);
        chk(rd_data == 8'hA7, "R6 restart self-clears", rd_data, 8'hA7);
        wr(8'h5A);
        chk(rd_data == 8'h42, "R1 field mapping", rd_data, 8'h42);
        @(negedge clk);
        chk(rd_data == 8'h02, "R1 R6 after clear", rd_data, 8'h02);

        // R2/R3: sweep every prescaler code, R4 on the short ones
        for (int c = 0; c < 8; c++) begin
            do_reset();
            wr(8'h80 | 8'(c));
            wait_pulse(period(c), $sformatf("R2 R3 code %0d", c));
            if (c < 2) begin
                @(negedge clk);
                chk(tmo_req == 1'b0, "R4 one-cycle pulse", tmo_req, 0);
                wait_pulse(period(c) - 1, "R4 wrap period");
            end
        end

        // R9: idle suspends when idle-run bit is 0
        do_reset();
        wr(8'h81);
        run_quiet(50, "R9 before idle");
        idle = 1'b1;
        run_quiet(100, "R9 during idle");
        idle = 1'b0;
        wait_pulse(period(1) - 50, "R9 delayed by idle");

        // R10: idle ignored when idle-run bit is 1
        do_reset();
        wr(8'hA1);
        run_quiet(50, "R10 before idle");
        idle = 1'b1;
        run_quiet(100, "R10 during idle");
        idle = 1'b0;
        wait_pulse(period(1) - 150, "R10 idle ignored");

        // R5/R6: restart mid-count
        do_reset();
        wr(8'h81);
        run_quiet(200, "R5 before restart");
        wr(8'hC1);
        chk(rd_data == 8'hC1, "R6 restart visible", rd_data, 8'hC1);
        @(negedge clk);
        chk(rd_data == 8'h81, "R6 restart cleared", rd_data, 8'h81);
        wait_pulse(period(1), "R5 full period after restart");

        // R8: disabled, then hold and resume
        do_reset();
        wr(8'h00);
        run_quiet(3 * period(0), "R8 disabled no request");
        wr(8'h80);
        run_quiet(100, "R8 partial run");
        wr(8'h00);
        run_quiet(400, "R8 held while off");
        wr(8'h80);
        wait_pulse(period(0) - 101, "R8 resume from held count");

        // R7: reset mid-count restarts the full period
        do_reset();
        wr(8'h80);
        run_quiet(100, "R7 before reset");
        do_reset();
        chk(rd_data == 8'h00, "R7 reset clears register", rd_data, 0);
        wr(8'h80);
        wait_pulse(period(0), "R7 full period after reset");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule